// File: doc/BRIEF.md
# Burst Read Sequencer with Programmable Initial Latency

This block is the device-side sequencer of a synchronous burst-read memory. A host writes a small configuration register with a latency code and a burst mode. It then strobes an address-valid input together with a start address. The block counts the initial access latency, raises a ready signal, and then steps a word address pointer by one word per clock. The pointer feeds the memory array, which sits outside the block as a plain address-in, data-out store.

Two handshake flavours are chosen by an input that is sampled while reset is held. In the reduced flavour, the programmed latency is stretched by one cycle for an odd start address. It is stretched by two more cycles when the first fetch straddles a page boundary. In the standard flavour, every access takes seven cycles. An identification output reports which flavour is active. The pointer either runs linearly across the whole address space or wraps inside an aligned block of 8, 16 or 32 words.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, with no configuration write, a burst uses 7 initial access cycles in continuous mode, and wordValid and rdy are low.
- R2: In reduced mode, with an even start address and no boundary crossing, latency code c (cfgLatCode, 0 to 5) gives a first word exactly 2+c clocks after the edge that samples addrValid high with ceN low. Codes 6 and 7 behave as 7 cycles.
- R3: rdy rises one clock before the first word when the latency is 3 or more. With a latency of 2 it rises in the same clock as the first word. It stays high while words are presented.
- R4: In reduced mode an odd start address adds 1 cycle. A boundary crossing adds 2 cycles. A boundary crossing is continuous mode with start address bits [5:2] all ones.
- R5: In standard mode the latency is 7 cycles for every start address. The latency code in a configuration write has no effect.
- R6: Burst modes are encoded on cfgBurstMode as 0 = continuous, 1 = wrap 8, 2 = wrap 16, 3 = wrap 32. A wrap burst counts up to the end of its aligned block, returns to the block's first word and repeats. It never leaves the block, so it never crosses a 64-word boundary.
- R7: In continuous mode the pointer increments by one per word and wraps from the highest address to zero.
- R8: ceN high ends any access. wordValid and rdy are low from the next clock until a new start.
- R9: addrValid sampled during a burst abandons that burst and starts a new access at the new address, with its own latency.
- R10: idReducedHs reports the reducedHsIn value sampled during reset. Later changes of reducedHsIn affect neither this output nor the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| reducedHsIn | input | 1 | Handshake flavour strap, 1 = reduced, sampled during reset |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgLatCode | input | 3 | Latency code for the configuration write |
| cfgBurstMode | input | 2 | Burst mode for the configuration write |
| ceN | input | 1 | Active-low chip enable |
| addrValid | input | 1 | Start-address strobe, active high |
| startAddr | input | ADDR_W | Start word address |
| wordAddr | output | ADDR_W | Word address presented to the array |
| wordValid | output | 1 | A data word is presented this clock |
| rdy | output | 1 | Ready handshake to the host |
| idReducedHs | output | 1 | Identification: reduced handshake active |

## Verification
A wrong latency count shows at the ports as a first wordValid that comes a whole number of clocks early or late. rdy moves with it, so one burst per latency code, parity and boundary case exposes the error within ten clocks of the start strobe. A wrong wrap mask or carry shows as a wordAddr that leaves its aligned block or skips a word on the next presented word. Every word of a full wrap period is compared. Abort and restart faults show as wordValid or rdy still high one clock after ceN rises or a new strobe arrives.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [1:0] {
    BM_CONT   = 2'd0,
    BM_WRAP8  = 2'd1,
    BM_WRAP16 = 2'd2,
    BM_WRAP32 = 2'd3
  } burstMode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } seqState_e;

  // strobes from control to the address datapath
  typedef struct packed {
    logic loadStart;
    logic advance;
  } seqStrobe_t;

  localparam logic [2:0] LAT_CODE_RESET    = 3'b101;
  localparam logic [2:0] LAT_CODE_STANDARD = 3'b101;
  localparam int         LAT_W             = 4;
  localparam int         WRAP_COUNT        = 3;
  localparam int         WRAP_MIN_W        = 3;

endpackage

// File: rtl/brs_cfg.sv
module brs_cfg
  import brs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reducedHsIn,
  input  logic             cfgWrite,
  input  logic [2:0]       cfgLatCode,
  input  logic [1:0]       cfgBurstMode,
  output logic             hsReduced,
  output logic [LAT_W-1:0] baseLat,
  output burstMode_e       burstMode
);

  logic [2:0] latCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCode   <= LAT_CODE_RESET;
      burstMode <= BM_CONT;
      hsReduced <= reducedHsIn;
    end else if (cfgWrite) begin
      latCode   <= hsReduced ? cfgLatCode : LAT_CODE_STANDARD;
      burstMode <= burstMode_e'(cfgBurstMode);
    end
  end

  // codes above 5 are reserved and saturate at the longest setting
  always_comb begin
    if (latCode > 3'd5) baseLat = LAT_W'(7);
    else                baseLat = LAT_W'(latCode) + LAT_W'(2);
  end

endmodule

// File: rtl/brs_dpath.sv
module brs_dpath
  import brs_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int PAGE_W  = 6,
  parameter int GROUP_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  burstMode_e        burstMode,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              startOdd,
  output logic              startBoundary
);

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] wrapNext [WRAP_COUNT];
  burstMode_e        modeQ;

  // one candidate per aligned wrap size: 8, 16 and 32 words
  for (genvar g = 0; g < WRAP_COUNT; g++) begin : gWrap
    localparam int K = WRAP_MIN_W + g;
    assign wrapNext[g] = {addrQ[ADDR_W-1:K], addrQ[K-1:0] + K'(1)};
  end

  always_comb begin
    unique case (modeQ)
      BM_WRAP8:  nextAddr = wrapNext[0];
      BM_WRAP16: nextAddr = wrapNext[1];
      BM_WRAP32: nextAddr = wrapNext[2];
      default:   nextAddr = addrQ + ADDR_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      modeQ <= BM_CONT;
    end else if (strobe.loadStart) begin
      addrQ <= startAddr;
      modeQ <= burstMode;
    end else if (strobe.advance) begin
      addrQ <= nextAddr;
    end
  end

  assign wordAddr      = addrQ;
  assign startOdd      = startAddr[0];
  assign startBoundary = (burstMode == BM_CONT) && (&startAddr[PAGE_W-1:GROUP_W]);

endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             addrValid,
  input  logic             hsReduced,
  input  logic [LAT_W-1:0] baseLat,
  input  logic             startOdd,
  input  logic             startBoundary,
  output seqStrobe_t       strobe,
  output logic             wordValid,
  output logic             rdy
);

  seqState_e        state;
  logic [LAT_W-1:0] cnt;
  logic [LAT_W-1:0] effLat;
  logic             latTwo;
  logic             startEv;

  assign startEv = addrValid && !ceN;

  always_comb begin
    if (hsReduced)
      effLat = baseLat + LAT_W'(startOdd) + {startBoundary, 1'b0};
    else
      effLat = baseLat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      latTwo <= 1'b0;
    end else if (ceN) begin
      state <= ST_IDLE;
    end else if (startEv) begin
      state  <= ST_WAIT;
      cnt    <= effLat;
      latTwo <= (effLat == LAT_W'(2));
    end else if (state == ST_WAIT) begin
      if (cnt == LAT_W'(1)) state <= ST_BURST;
      else                  cnt   <= cnt - LAT_W'(1);
    end
  end

  always_comb begin
    strobe.loadStart = startEv;
    strobe.advance   = (state == ST_BURST) && !ceN && !startEv;
  end

  assign wordValid = (state == ST_BURST);
  assign rdy       = (state == ST_BURST) ||
                     ((state == ST_WAIT) && (cnt == LAT_W'(1)) && !latTwo);

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brs_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int PAGE_W  = 6,
  parameter int GROUP_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reducedHsIn,
  input  logic              cfgWrite,
  input  logic [2:0]        cfgLatCode,
  input  logic [1:0]        cfgBurstMode,
  input  logic              ceN,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              wordValid,
  output logic              rdy,
  output logic              idReducedHs
);

  logic             hsReduced;
  logic [LAT_W-1:0] baseLat;
  burstMode_e       burstMode;
  seqStrobe_t       strobe;
  logic             startOdd;
  logic             startBoundary;

  brs_cfg uCfg (
    .clk(clk), .rstN(rstN), .reducedHsIn(reducedHsIn),
    .cfgWrite(cfgWrite), .cfgLatCode(cfgLatCode), .cfgBurstMode(cfgBurstMode),
    .hsReduced(hsReduced), .baseLat(baseLat), .burstMode(burstMode)
  );

  brs_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .addrValid(addrValid),
    .hsReduced(hsReduced), .baseLat(baseLat),
    .startOdd(startOdd), .startBoundary(startBoundary),
    .strobe(strobe), .wordValid(wordValid), .rdy(rdy)
  );

  brs_dpath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .GROUP_W(GROUP_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .burstMode(burstMode), .wordAddr(wordAddr),
    .startOdd(startOdd), .startBoundary(startBoundary)
  );

  assign idReducedHs = hsReduced;

endmodule

// File: rtl/brs_chk.sv
module brs_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       addrValid,
  input logic       wordValid,
  input logic       rdy,
  input logic [2:0] stepBits,
  input logic       idReducedHs
);

  // R3: a presented word always carries ready
  a_r3_rdy_with_word: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> rdy);

  // R3: an early ready is followed by the word on the next clock
  a_r3_rdy_leads_word: assert property (@(posedge clk) disable iff (!rstN)
    (rdy && !wordValid && !ceN && !addrValid) |=> wordValid);

  // R8: chip enable high ends the access
  a_r8_ce_abort: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> (!wordValid && !rdy));

  // R9: a new strobe abandons the running burst
  a_r9_restart: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !ceN) |=> (!wordValid && !rdy));

  // R6, R7: consecutive words step the low three address bits by one in every mode
  a_r6_low_bits_step: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && $past(wordValid)) |-> (stepBits == 3'($past(stepBits) + 3'd1)));

  // R10: identification does not move outside reset
  a_r10_id_stable: assert property (@(posedge clk) disable iff (!rstN)
    $stable(idReducedHs));

endmodule

bind burst_read_seq brs_chk uChk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .addrValid(addrValid),
  .wordValid(wordValid), .rdy(rdy), .stepBits(wordAddr[2:0]),
  .idReducedHs(idReducedHs)
);

// File: tb/burst_read_seq_test.sv
module burst_read_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 22;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reducedHsIn = 1'b1;
  logic          cfgWrite = 1'b0;
  logic [2:0]    cfgLatCode = '0;
  logic [1:0]    cfgBurstMode = '0;
  logic          ceN = 1'b1;
  logic          addrValid = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [AW-1:0] wordAddr;
  logic          wordValid;
  logic          rdy;
  logic          idReducedHs;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_read_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .reducedHsIn(reducedHsIn),
    .cfgWrite(cfgWrite), .cfgLatCode(cfgLatCode), .cfgBurstMode(cfgBurstMode),
    .ceN(ceN), .addrValid(addrValid), .startAddr(startAddr),
    .wordAddr(wordAddr), .wordValid(wordValid), .rdy(rdy),
    .idReducedHs(idReducedHs)
  );

  // {latency code, burst mode, start address, expected latency}, reduced mode
  localparam int NVEC = 10;
  localparam logic [30:0] VEC [NVEC] = '{
    {3'd0, 2'd0, 22'h000100, 4'd2},
    {3'd1, 2'd0, 22'h000102, 4'd3},
    {3'd2, 2'd1, 22'h000204, 4'd4},
    {3'd3, 2'd2, 22'h00030A, 4'd5},
    {3'd4, 2'd3, 22'h00041C, 4'd6},
    {3'd5, 2'd1, 22'h000007, 4'd8},
    {3'd2, 2'd0, 22'h00013D, 4'd7},
    {3'd2, 2'd0, 22'h00003C, 4'd6},
    {3'd2, 2'd1, 22'h00003E, 4'd4},
    {3'd6, 2'd0, 22'h000010, 4'd7}
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] nextA(input logic [AW-1:0] a, input logic [1:0] mode);
    logic [AW-1:0] m;
    if (mode == 2'd0) return a + 1'b1;
    m = (AW'(1) << (mode + 2)) - 1'b1;
    return (a & ~m) | ((a + 1'b1) & m);
  endfunction

  task automatic doReset(input logic hs);
    rstN = 1'b0; reducedHsIn = hs; ceN = 1'b1; addrValid = 1'b0; cfgWrite = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeCfg(input logic [2:0] code, input logic [1:0] mode);
    cfgWrite = 1'b1; cfgLatCode = code; cfgBurstMode = mode;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic startBurst(input logic [AW-1:0] a);
    ceN = 1'b0; addrValid = 1'b1; startAddr = a;
    @(negedge clk);
    addrValid = 1'b0;
  endtask

  // called right after the start edge; returns clocks to rdy and to the first word
  task automatic measure(output int latN, output int rdyN);
    latN = -1; rdyN = -1;
    for (int n = 0; n < 16; n++) begin
      if (rdy && rdyN < 0) rdyN = n;
      if (wordValid) begin latN = n; break; end
      @(negedge clk);
    end
  endtask

  task automatic checkLat(input string tag, input int expLat);
    int latN, rdyN;
    measure(latN, rdyN);
    chk({tag, " latency"}, latN, expLat);
    chk({"R3 rdy lead ", tag}, rdyN, (expLat > 2) ? expLat - 1 : expLat);
  endtask

  task automatic checkSeq(input string tag, input logic [AW-1:0] a0,
                          input logic [1:0] mode, input int count);
    logic [AW-1:0] e = a0;
    for (int i = 0; i < count; i++) begin
      chk({tag, " addr"}, wordAddr, e);
      chk({tag, " valid"}, wordValid, 1);
      e = nextA(e, mode);
      @(negedge clk);
    end
  endtask

  task automatic endBurst();
    ceN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state and default latency, R10 identification
    doReset(1'b1);
    chk("R1 wordValid after reset", wordValid, 0);
    chk("R1 rdy after reset", rdy, 0);
    chk("R10 id reduced", idReducedHs, 1);
    startBurst(22'h000020);
    checkLat("R1 default", 7);
    checkSeq("R1 continuous default", 22'h000020, 2'd0, 4);
    endBurst();

    // R2 R4 R6 table walk in reduced mode
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] code = VEC[v][30:28];
      logic [1:0] mode = VEC[v][27:26];
      logic [AW-1:0] a = VEC[v][25:4];
      int lat = int'(VEC[v][3:0]);
      writeCfg(code, mode);
      startBurst(a);
      checkLat("R2 R4 table", lat);
      checkSeq("R6 table", a, mode, (mode == 2'd0) ? 6 : (4 << mode) + 2);
      endBurst();
    end

    // R7 wrap from highest address to zero (even start at boundary: 2+2)
    writeCfg(3'd0, 2'd0);
    startBurst(22'h3FFFFE);
    checkLat("R7 top", 4);
    checkSeq("R7 top wrap", 22'h3FFFFE, 2'd0, 4);
    endBurst();

    // R8 abort by chip enable
    writeCfg(3'd1, 2'd0);
    startBurst(22'h000050);
    checkLat("R8 pre", 3);
    checkSeq("R8 pre", 22'h000050, 2'd0, 2);
    ceN = 1'b1;
    @(negedge clk);
    chk("R8 wordValid after ceN", wordValid, 0);
    chk("R8 rdy after ceN", rdy, 0);
    ceN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 stays idle", wordValid, 0);
    chk("R8 rdy stays low", rdy, 0);

    // R9 restart during a burst
    writeCfg(3'd2, 2'd0);
    startBurst(22'h000080);
    checkLat("R9 first", 4);
    checkSeq("R9 first", 22'h000080, 2'd0, 2);
    startBurst(22'h000091);
    chk("R9 old burst dropped", wordValid, 0);
    checkLat("R9 restart", 5);
    checkSeq("R9 restart", 22'h000091, 2'd0, 3);
    endBurst();

    // R5 standard mode, R10 identification
    doReset(1'b0);
    chk("R10 id standard", idReducedHs, 0);
    writeCfg(3'd0, 2'd0);
    startBurst(22'h00003D);
    checkLat("R5 odd boundary", 7);
    endBurst();
    startBurst(22'h000040);
    checkLat("R5 even", 7);
    checkSeq("R5 seq", 22'h000040, 2'd0, 3);
    endBurst();

    // R10 strap change after reset has no effect
    reducedHsIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 id after strap change", idReducedHs, 0);
    startBurst(22'h000041);
    checkLat("R10 latency after strap change", 7);
    endBurst();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule